// File: doc/BRIEF.md
# Stack-Machine Integer Add Sequencer

This block runs the integer-add bytecode of a stack-based processor as a fixed chain of micro-steps. The operand stack sits in an external RAM with one-cycle synchronous reads. The stack pointer addresses the top entry, and the valid entries are at indices 1 to `sp`. A start request carrying the add opcode is accepted only while the sequencer is idle and the stack holds at least two entries.

Once a request is accepted, the block pops the top entry and then the entry below it. Each pop takes three micro-steps: latch the address and decrement the pointer, issue the RAM read, then capture the read data while zeroing the vacated slot. The two operands then move into ALU registers A and B together. The adder result goes into a sum stage and then into the ALU output register. The push copies that value into the data-out register, steps the pointer back up by one, reloads the address and writes the sum.

Every stage raises a validity flag, and the next stage advances only when that flag is set. The retire step clears the flags, pulses `done` and returns the block to idle. A request that cannot be taken is dropped and flagged by a one-cycle error pulse.

Top module: `stk_add_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `ram_wr` are 0 and `sp` is 0.
- R2: A start with `opcode` equal to ADD_OP (default 8'h60), taken while idle with `sp` greater than 1, drives `busy` high from the next cycle. `done` rises exactly 12 cycles after the accepting edge, and `busy` is low in the cycle after `done`.
- R3: After retire, the entry at the starting `sp - 1` holds the old entry at `sp` plus the old entry at `sp - 1`, wrapped modulo 2^DW.
- R4: After retire, `sp` equals its starting value minus one.
- R5: After retire, the vacated slot at the starting `sp` holds zero, and every other stack entry is unchanged.
- R6: An add request taken while idle with `sp` of 0 or 1 is ignored. `err` is high for exactly the next cycle, `busy` stays low, and the stack and `sp` are unchanged.
- R7: An add request arriving while `busy` is high is ignored and pulses `err` in the next cycle. The add in progress completes with the normal result and timing.
- R8: A start whose `opcode` differs from ADD_OP is ignored with no error. `busy` stays low, and the stack and `sp` are unchanged.
- R9: `done` is a single-cycle pulse. In that cycle `ram_wr` is high and `ram_wdata` carries the sum.
- R10: Each add issues exactly two RAM reads, and `ram_rd` and `ram_wr` are never high in the same cycle.
- R11: `sp_load` copies `sp_val` into `sp` when the block is idle and no add is being accepted in the same cycle. While busy, `sp_load` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Bytecode execute request |
| opcode | input | OPW | Bytecode presented with `start` |
| sp_load | input | 1 | Load the stack pointer while idle |
| sp_val | input | AW | Value for `sp_load` |
| busy | output | 1 | Sequencer is active |
| done | output | 1 | Retire pulse |
| err | output | 1 | Rejected add request pulse |
| sp | output | AW | Current stack pointer |
| ram_addr | output | AW | Stack RAM address |
| ram_rd | output | 1 | Stack RAM read enable (data valid next cycle) |
| ram_rdata | input | DW | Stack RAM read data |
| ram_wr | output | 1 | Stack RAM write enable |
| ram_wdata | output | DW | Stack RAM write data |

## Verification
The assertions assume that `start` is held for one cycle per request, so each rejected request gives exactly one error pulse. They also assume that the RAM returns read data one cycle after `ram_rd`. The bench drives every request as a single-cycle pulse, models the RAM with exactly that latency, and sets the pointer with `sp_load` only between instructions, except for the deliberate load during an add that checks it is ignored. Random pointer values cover 0 to 63, with directed cases at 1, 2, 63 and an overflowing sum.

// File: rtl/stk_add_pkg.sv
`timescale 1ns/1ps
// Package: shared micro-step encoding and validity-flag bundle for the add sequencer.
package stk_add_pkg;

    // Micro-steps of the add sequence, in execution order.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_ADDR,
        ST_A_READ,
        ST_A_CAP,
        ST_B_ADDR,
        ST_B_READ,
        ST_B_CAP,
        ST_LOAD_AB,
        ST_ADD,
        ST_LATCH,
        ST_PUSH_INC,
        ST_PUSH_ADDR,
        ST_RETIRE
    } step_t;

    // Validity flags raised by the datapath stages.
    typedef struct packed {
        logic din;
        logic dout;
        logic a;
        logic b;
        logic out;
    } vflags_t;

endpackage

// File: rtl/stk_add_ctrl.sv
`timescale 1ns/1ps
// Module: stk_add_ctrl
// Micro-step sequencer. It owns the status, the stack pointer and the RAM
// address register. It accepts an add request only while idle with sp > 1,
// and it leaves each step only when the datapath flag that the step depends
// on is valid.
// Assumes: start is a single-cycle request; sp_load is applied only while idle.
module stk_add_ctrl
    import stk_add_pkg::*;
#(
    parameter int AW     = 6,
    parameter int OPW    = 8,
    parameter logic [OPW-1:0] ADD_OP = 8'h60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [OPW-1:0] opcode,
    input  logic          sp_load,
    input  logic [AW-1:0] sp_val,
    input  vflags_t       flg,
    output step_t         step,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] addr,
    output logic          err
);

    localparam logic [AW-1:0] MIN_SP = AW'(1);

    step_t nxt;
    logic  req;
    logic  accept;

    // Decode an add request and decide whether it can be accepted.
    always_comb begin
        req    = start && (opcode == ADD_OP);
        accept = req && (step == ST_IDLE) && (sp > MIN_SP);
    end

    // Next micro-step, each advance gated by its predecessor's flag.
    always_comb begin
        nxt = step;
        case (step)
            ST_IDLE:      if (accept) nxt = ST_A_ADDR;
            ST_A_ADDR:    nxt = ST_A_READ;
            ST_A_READ:    nxt = ST_A_CAP;
            ST_A_CAP:     nxt = ST_B_ADDR;
            ST_B_ADDR:    if (flg.din) nxt = ST_B_READ;
            ST_B_READ:    nxt = ST_B_CAP;
            ST_B_CAP:     nxt = ST_LOAD_AB;
            ST_LOAD_AB:   if (flg.din) nxt = ST_ADD;
            ST_ADD:       if (flg.a && flg.b) nxt = ST_LATCH;
            ST_LATCH:     if (flg.a && flg.b) nxt = ST_PUSH_INC;
            ST_PUSH_INC:  if (flg.out && !flg.dout) nxt = ST_PUSH_ADDR;
            ST_PUSH_ADDR: if (flg.dout) nxt = ST_RETIRE;
            ST_RETIRE:    if (flg.dout) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_IDLE;
        else        step <= nxt;
    end

    // Stack pointer and RAM address register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp   <= '0;
            addr <= '0;
        end else begin
            case (step)
                ST_IDLE: if (sp_load && !accept) sp <= sp_val;
                ST_A_ADDR, ST_B_ADDR: begin
                    addr <= sp;
                    sp   <= sp - AW'(1);
                end
                ST_PUSH_INC:  sp   <= sp + AW'(1);
                ST_PUSH_ADDR: addr <= sp;
                default: ;
            endcase
        end
    end

    // One-cycle error pulse for a rejected add request.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= req && !accept;
    end

endmodule

// File: rtl/stk_add_dp.sv
`timescale 1ns/1ps
// Module: stk_add_dp
// Datapath registers: data-in capture, held top operand, ALU A/B, sum stage,
// ALU output and data-out. Each stage sets its validity flag, and retire
// clears the ALU and data-out flags.
// Assumes: RAM read data is valid in the step after the read step.
module stk_add_dp
    import stk_add_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  step_t         step,
    input  logic [DW-1:0] ram_rdata,
    output vflags_t       flg,
    output logic [DW-1:0] ram_wdata
);

    logic [DW-1:0] din_q;
    logic [DW-1:0] top_q;
    logic [DW-1:0] alu_a;
    logic [DW-1:0] alu_b;
    logic [DW-1:0] sum_q;
    logic [DW-1:0] alu_out;
    logic [DW-1:0] dout_q;

    // Operand capture and ALU pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q   <= '0;
            top_q   <= '0;
            alu_a   <= '0;
            alu_b   <= '0;
            sum_q   <= '0;
            alu_out <= '0;
            dout_q  <= '0;
        end else begin
            case (step)
                ST_A_CAP, ST_B_CAP: din_q <= ram_rdata;
                ST_B_ADDR:   top_q <= din_q;
                ST_LOAD_AB: begin
                    alu_a <= top_q;
                    alu_b <= din_q;
                end
                ST_ADD:      sum_q   <= alu_a + alu_b;
                ST_LATCH:    alu_out <= sum_q;
                ST_PUSH_INC: dout_q  <= alu_out;
                default: ;
            endcase
        end
    end

    // Validity flags: set by each stage, cleared when consumed or at retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg <= '0;
        end else begin
            case (step)
                ST_A_CAP, ST_B_CAP: flg.din <= 1'b1;
                ST_B_ADDR:   flg.din <= 1'b0;
                ST_LOAD_AB: begin
                    flg.din <= 1'b0;
                    flg.a   <= 1'b1;
                    flg.b   <= 1'b1;
                end
                ST_LATCH:    flg.out  <= 1'b1;
                ST_PUSH_INC: flg.dout <= 1'b1;
                ST_RETIRE: begin
                    flg.dout <= 1'b0;
                    flg.a    <= 1'b0;
                    flg.b    <= 1'b0;
                    flg.out  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Write data: the sum at retire, zero when scrubbing a popped slot.
    always_comb begin
        ram_wdata = (step == ST_RETIRE) ? dout_q : '0;
    end

endmodule

// File: rtl/stk_add_seq.sv
`timescale 1ns/1ps
// Module: stk_add_seq (top)
// Microcoded integer-add sequencer for a RAM-backed operand stack. It joins
// the step controller and the datapath, and it decodes the RAM strobes and
// the status outputs from the current step.
// Assumes: external RAM with one-cycle synchronous read, write on the clock edge.
module stk_add_seq
    import stk_add_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 6,
    parameter int OPW = 8,
    parameter logic [OPW-1:0] ADD_OP = 8'h60
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] opcode,
    input  logic           sp_load,
    input  logic [AW-1:0]  sp_val,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic [AW-1:0]  sp,
    output logic [AW-1:0]  ram_addr,
    output logic           ram_rd,
    input  logic [DW-1:0]  ram_rdata,
    output logic           ram_wr,
    output logic [DW-1:0]  ram_wdata
);

    step_t   step;
    vflags_t flg;

    stk_add_ctrl #(.AW(AW), .OPW(OPW), .ADD_OP(ADD_OP)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .opcode (opcode),
        .sp_load(sp_load),
        .sp_val (sp_val),
        .flg    (flg),
        .step   (step),
        .sp     (sp),
        .addr   (ram_addr),
        .err    (err)
    );

    stk_add_dp #(.DW(DW)) i_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .ram_rdata(ram_rdata),
        .flg      (flg),
        .ram_wdata(ram_wdata)
    );

    // Status and RAM strobe decode from the current step.
    always_comb begin
        busy   = (step != ST_IDLE);
        done   = (step == ST_RETIRE);
        ram_rd = (step == ST_A_READ) || (step == ST_B_READ);
        ram_wr = (step == ST_A_CAP) || (step == ST_B_CAP) || (step == ST_RETIRE);
    end

endmodule

// File: rtl/stk_add_chk.sv
`timescale 1ns/1ps
// Module: stk_add_chk
// Property checker bound to stk_add_seq. It watches the status pulses, the
// RAM strobes, the pointer and the datapath validity flags.
// Assumes: start requests last one cycle.
module stk_add_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          sp_load,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] sp,
    input logic          ram_rd,
    input logic          ram_wr,
    input logic          v_a,
    input logic          v_b,
    input logic          v_out,
    input logic          v_dout
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R9
    AST_DONE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ram_wr);                                          // R9
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                           // R2
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(start));                                     // R6
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);                                             // R6
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));                                      // R10
    AST_SP_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sp_load) |=> $stable(sp));                      // R11
    AST_PUSH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        v_dout |-> (v_out && v_a && v_b));                         // R3
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !(v_a || v_b || v_out || v_dout));                // R2

endmodule

bind stk_add_seq stk_add_chk #(.AW(AW)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .sp_load(sp_load),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .sp     (sp),
    .ram_rd (ram_rd),
    .ram_wr (ram_wr),
    .v_a    (flg.a),
    .v_b    (flg.b),
    .v_out  (flg.out),
    .v_dout (flg.dout)
);

// File: tb/test_stk_add_seq.sv
`timescale 1ns/1ps
// Bench for stk_add_seq: seeded random operations mixed with directed corners.
module test_stk_add_seq;

    localparam int DW = 32;
    localparam int AW = 6;
    localparam int OPW = 8;
    localparam logic [OPW-1:0] ADD_OP = 8'h60;
    localparam int DEPTH = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [OPW-1:0] opcode = '0;
    logic           sp_load = 1'b0;
    logic [AW-1:0]  sp_val = '0;
    logic           busy, done, err, ram_rd, ram_wr;
    logic [AW-1:0]  sp, ram_addr;
    logic [DW-1:0]  ram_rdata, ram_wdata;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] expm [DEPTH];
    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int coll = 0;
    int adds = 0;

    always #4 clk = ~clk;

    stk_add_seq #(.DW(DW), .AW(AW), .OPW(OPW), .ADD_OP(ADD_OP)) i_stk_add_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .sp_load(sp_load), .sp_val(sp_val), .busy(busy), .done(done),
        .err(err), .sp(sp), .ram_addr(ram_addr), .ram_rd(ram_rd),
        .ram_rdata(ram_rdata), .ram_wr(ram_wr), .ram_wdata(ram_wdata)
    );

    // Stack RAM model: synchronous read with one cycle of latency.
    always @(posedge clk) begin
        if (ram_wr) mem[ram_addr] <= ram_wdata;
        if (ram_rd) ram_rdata <= mem[ram_addr];
        if (ram_rd && ram_wr) coll <= coll + 1;
        if (ram_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] add_ref(input logic [DW-1:0] x, input logic [DW-1:0] y);
        return x + y;
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]  = $urandom;
            expm[i] = mem[i];
        end
    endtask

    task automatic load_sp(input int v);
        @(negedge clk);
        sp_load = 1'b1;
        sp_val  = AW'(v);
        @(negedge clk);
        sp_load = 1'b0;
        check(sp == AW'(v), "R11 sp load", DW'(sp), DW'(v));
    endtask

    // Count stack entries that differ from the expected image.
    function automatic int mism();
        int m = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== expm[i]) m++;
        return m;
    endfunction

    task automatic run_add(input int sp0, input bit inj, input bit wrap);
        int n;
        load_sp(sp0);
        fill_mem();
        if (wrap) begin
            mem[sp0] = 32'hFFFF_FFFF; mem[sp0-1] = 32'h2;
            expm[sp0] = mem[sp0]; expm[sp0-1] = mem[sp0-1];
        end
        @(negedge clk);
        start = 1'b1; opcode = ADD_OP;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check(busy == 1'b1, "R2 busy after accept", DW'(busy), 1);
        check(err == 1'b0, "R2 no error on accept", DW'(err), 0);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (inj && n == 5) check(err == 1'b1, "R7 err on busy start", DW'(err), 1);
            start   = inj && (n == 4);
            sp_load = inj && (n == 6);
            sp_val  = '0;
        end
        start = 1'b0; sp_load = 1'b0;
        check(n == 12, "R2 done latency", DW'(n), 12);
        check(ram_wr == 1'b1, "R9 write with done", DW'(ram_wr), 1);
        check(ram_wdata == add_ref(expm[sp0], expm[sp0-1]), "R9 wdata",
              ram_wdata, add_ref(expm[sp0], expm[sp0-1]));
        @(negedge clk);
        adds++;
        check(done == 1'b0, "R9 done pulse", DW'(done), 0);
        check(busy == 1'b0, "R2 idle after done", DW'(busy), 0);
        check(sp == AW'(sp0 - 1), "R4 final sp (R11 load ignored)", DW'(sp), DW'(sp0 - 1));
        check(mem[sp0-1] == add_ref(expm[sp0], expm[sp0-1]), "R3 sum",
              mem[sp0-1], add_ref(expm[sp0], expm[sp0-1]));
        if (wrap) check(mem[sp0-1] == 32'h1, "R3 wrap", mem[sp0-1], 32'h1);
        check(mem[sp0] == '0, "R5 vacated slot zero", mem[sp0], 0);
        expm[sp0-1] = add_ref(expm[sp0], expm[sp0-1]);
        expm[sp0] = '0;
        check(mism() == 0, "R5 other entries", DW'(mism()), 0);
    endtask

    task automatic try_bad(input int sp0);
        load_sp(sp0);
        fill_mem();
        @(negedge clk);
        start = 1'b1; opcode = ADD_OP;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, "R6 err pulse", DW'(err), 1);
        check(busy == 1'b0, "R6 stays idle", DW'(busy), 0);
        @(negedge clk);
        check(err == 1'b0, "R6 err one cycle", DW'(err), 0);
        check(sp == AW'(sp0), "R6 sp unchanged", DW'(sp), DW'(sp0));
        check(mism() == 0, "R6 stack unchanged", DW'(mism()), 0);
    endtask

    task automatic try_wrong(input int sp0);
        load_sp(sp0);
        fill_mem();
        @(negedge clk);
        start = 1'b1; opcode = ADD_OP ^ OPW'(1 + ($urandom % 255));
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b0, "R8 no err", DW'(err), 0);
        check(busy == 1'b0, "R8 stays idle", DW'(busy), 0);
        @(negedge clk);
        check(sp == AW'(sp0), "R8 sp unchanged", DW'(sp), DW'(sp0));
        check(mism() == 0, "R8 stack unchanged", DW'(mism()), 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && err == 1'b0 && ram_wr == 1'b0,
              "R1 outputs in reset", DW'({busy, done, err, ram_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sp == '0, "R1 sp after reset", DW'(sp), 0);
        // Directed corners.
        run_add(2, 1'b0, 1'b0);
        run_add(DEPTH - 1, 1'b0, 1'b0);
        run_add(10, 1'b0, 1'b1);
        run_add(7, 1'b1, 1'b0);
        try_bad(1);
        try_bad(0);
        try_wrong(5);
        // Seeded random mix.
        for (int k = 0; k < 60; k++) begin
            int kind = $urandom % 6;
            if (kind == 0)      try_bad($urandom % 2);
            else if (kind == 1) try_wrong(2 + ($urandom % (DEPTH - 2)));
            else run_add(2 + ($urandom % (DEPTH - 2)), ($urandom % 3) == 0, 1'b0);
        end
        @(negedge clk);
        check(coll == 0, "R10 read/write overlap", DW'(coll), 0);
        check(rd_cnt == 2 * adds, "R10 reads per add", DW'(rd_cnt), DW'(2 * adds));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule